// File: doc/BRIEF.md
# Accumulator Logic and Shift Unit

This unit performs the bitwise and single-bit shift work of an accumulator processor that can run in 8-bit or 16-bit mode. The caller supplies the accumulator, a memory operand, the incoming carry, an operation code, a width bit and an immediate-addressing flag, and pulses `start`. One cycle later the unit presents the result, where the result should be written (accumulator, memory or nowhere) and a write enable for each of the n, v, z and c flags, all with a one-cycle `valid` pulse. The unit keeps its own copy of the four flags. A flag changes only when its enable is set.

The operations are AND, OR, XOR, a bit test, test-and-set, test-and-reset, shift left, logical shift right, rotate left and rotate right. The bit test and the two test-and-modify operations compute z from the original operands, not from the written value. Shifts pass their outgoing bit into c. A shift followed by rotates therefore builds a shift over several words. In 8-bit mode only the low byte takes part, and the upper result byte is the accumulator's upper byte.

Top module: `logic_shift_unit`

## Requirements
- R1: Operation codes 0 (AND), 1 (OR) and 2 (XOR) combine `acc_i` with `mem_i` bitwise. The result goes to the accumulator (`dest_o` = 1). n is the result's top bit and z is set when the result is zero. v and c are not written.
- R2: Operation code 3 (bit test) writes nowhere (`dest_o` = 0). z is set when `acc_i & mem_i` is zero. When `imm_i` is low, n takes the memory operand's top bit and v takes the bit just below it. c is not written.
- R3: For the bit test with `imm_i` high, only z is written. n and v keep their previous values.
- R4: Operation code 4 (test-and-set) produces `mem_i | acc_i`. Operation code 5 (test-and-reset) produces `mem_i & ~acc_i`. Both target memory (`dest_o` = 2), and their z is computed from `acc_i & mem_i` before the change. Only z is written.
- R5: Operation code 6 (shift left) moves 0 into bit 0. Operation code 8 (rotate left) moves `c_i` into bit 0. In both, the old top bit goes to c.
- R6: Operation code 7 (logical shift right) moves 0 into the top bit. Operation code 9 (rotate right) moves `c_i` into the top bit. In both, the old bit 0 goes to c.
- R7: Shifts and rotates write n, z and c from their result, but not v. The source is the memory operand and the target is memory (`dest_o` = 2) when `mem_sel_i` is high. Otherwise the source and target are the accumulator (`dest_o` = 1).
- R8: With `wide_i` low, the top bits are 7 and 6, z looks at bits 7:0 only, and `res_o[15:8]` equals `acc_i[15:8]`. With `wide_i` high, all 16 bits are used and the top bits are 15 and 14.
- R9: A shift left on the low byte followed by rotate-lefts on higher bytes yields a correct multi-byte shift left when each step is fed the previous step's c. The same holds for a shift right started at the high byte followed by rotate-rights down to the low byte.
- R10: Results and enables appear on the cycle after `start`, with `valid_o` high for exactly that one cycle. `valid_o`, `dest_o` and the write enables are zero on all other cycles.
- R11: A flag whose write enable is low keeps its value. Reset clears all four flags, `res_o` and `valid_o`.
- R12: Operation codes 10 to 15 produce `valid_o` with `dest_o` = 0 and no write enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 = 16-bit, 0 = 8-bit |
| imm_i | input | 1 | Immediate addressing (bit test) |
| mem_sel_i | input | 1 | Shift source/target is memory |
| acc_i | input | 16 | Accumulator value |
| mem_i | input | 16 | Memory operand |
| c_i | input | 1 | Incoming carry |
| res_o | output | 16 | Result value |
| dest_o | output | 2 | 0 none, 1 accumulator, 2 memory |
| valid_o | output | 1 | Result valid pulse |
| n_o | output | 1 | Negative flag |
| v_o | output | 1 | Overflow flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| n_we_o | output | 1 | n written this result |
| v_we_o | output | 1 | v written this result |
| z_we_o | output | 1 | z written this result |
| c_we_o | output | 1 | c written this result |

## Verification
The bench targets test-and-set and test-and-reset on operands where the written value is nonzero but the original AND is zero. A design that took z from the written value would report the wrong zero flag there. It runs the bit test both with and without immediate addressing, to catch a design that overwrites n and v from an immediate operand. It shifts in 8-bit mode with bits set in the upper byte, which shows up a design that takes its carry or top bit from bit 15, or lets the upper byte leak into z. It builds 32-bit shifts from chained byte operations, so a carry that is inverted or taken from the wrong end breaks the assembled word.

// File: rtl/logic_shift_unit.sv
module logic_shift_unit #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   op_i,
  input  logic         wide_i,
  input  logic         imm_i,
  input  logic         mem_sel_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mem_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic [1:0]   dest_o,
  output logic         valid_o,
  output logic         n_o,
  output logic         v_o,
  output logic         z_o,
  output logic         c_o,
  output logic         n_we_o,
  output logic         v_we_o,
  output logic         z_we_o,
  output logic         c_we_o
);
  localparam logic [3:0] OP_AND = 4'd0, OP_OR = 4'd1, OP_XOR = 4'd2, OP_TST = 4'd3,
                         OP_SET = 4'd4, OP_CLR = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
                         OP_RTL = 4'd8, OP_RTR = 4'd9;
  localparam logic [1:0] TO_NONE = 2'd0, TO_ACC = 2'd1, TO_MEM = 2'd2;

  logic [W-1:0] src, raw, res;
  logic [1:0]   dst;
  logic [3:0]   we;
  logic         n_nx, v_nx, z_nx, c_nx;
  logic         src_top, mem_top, mem_nxt, z_and, z_res;

  assign src     = mem_sel_i ? mem_i : acc_i;
  assign src_top = wide_i ? src[W-1] : src[H-1];
  assign mem_top = wide_i ? mem_i[W-1] : mem_i[H-1];
  assign mem_nxt = wide_i ? mem_i[W-2] : mem_i[H-2];
  assign z_and   = wide_i ? ((acc_i & mem_i) == '0) : ((acc_i[H-1:0] & mem_i[H-1:0]) == '0);
  assign res     = wide_i ? raw : {acc_i[W-1:H], raw[H-1:0]};
  assign z_res   = wide_i ? (res == '0) : (res[H-1:0] == '0);

  always_comb begin
    raw  = acc_i;
    dst  = TO_NONE;
    we   = 4'b0000;
    c_nx = 1'b0;
    n_nx = wide_i ? res[W-1] : res[H-1];
    v_nx = 1'b0;
    z_nx = z_res;
    unique case (op_i)
      OP_AND: begin raw = acc_i & mem_i; dst = TO_ACC; we = 4'b1010; end
      OP_OR:  begin raw = acc_i | mem_i; dst = TO_ACC; we = 4'b1010; end
      OP_XOR: begin raw = acc_i ^ mem_i; dst = TO_ACC; we = 4'b1010; end
      OP_TST: begin
        n_nx = mem_top;
        v_nx = mem_nxt;
        z_nx = z_and;
        we   = imm_i ? 4'b0010 : 4'b1110;
      end
      OP_SET: begin raw = mem_i | acc_i;  dst = TO_MEM; z_nx = z_and; we = 4'b0010; end
      OP_CLR: begin raw = mem_i & ~acc_i; dst = TO_MEM; z_nx = z_and; we = 4'b0010; end
      OP_SHL, OP_RTL: begin
        raw  = {src[W-2:0], (op_i == OP_RTL) & c_i};
        c_nx = src_top;
        dst  = mem_sel_i ? TO_MEM : TO_ACC;
        we   = 4'b1011;
      end
      OP_SHR, OP_RTR: begin
        raw  = {(op_i == OP_RTR) & c_i, src[W-1:1]};
        if (!wide_i) raw[H-1] = (op_i == OP_RTR) & c_i;
        c_nx = src[0];
        dst  = mem_sel_i ? TO_MEM : TO_ACC;
        we   = 4'b1011;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o   <= '0;
      dest_o  <= TO_NONE;
      valid_o <= 1'b0;
      {n_o, v_o, z_o, c_o} <= 4'b0000;
      {n_we_o, v_we_o, z_we_o, c_we_o} <= 4'b0000;
    end else begin
      valid_o <= start;
      dest_o  <= start ? dst : TO_NONE;
      {n_we_o, v_we_o, z_we_o, c_we_o} <= start ? we : 4'b0000;
      if (start) begin
        res_o <= res;
        if (we[3]) n_o <= n_nx;
        if (we[2]) v_o <= v_nx;
        if (we[1]) z_o <= z_nx;
        if (we[0]) c_o <= c_nx;
      end
    end
  end
endmodule

module logic_shift_unit_chk #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   op_i,
  input logic         wide_i,
  input logic         imm_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] res_o,
  input logic [1:0]   dest_o,
  input logic         valid_o,
  input logic         n_o,
  input logic         v_o,
  input logic         z_o,
  input logic         c_o,
  input logic         n_we_o,
  input logic         v_we_o,
  input logic         z_we_o,
  input logic         c_we_o
);
  p_start_valid_r10: assert property (@(posedge clk) disable iff (!rst_n) start |=> valid_o);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!valid_o && dest_o == 2'd0 && !n_we_o && !v_we_o && !z_we_o && !c_we_o));
  p_n_hold_r11: assert property (@(posedge clk) disable iff (!rst_n) !n_we_o |-> n_o == $past(n_o));
  p_c_hold_r11: assert property (@(posedge clk) disable iff (!rst_n) !c_we_o |-> c_o == $past(c_o));
  p_test_nodest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_i == 4'd3) |=> (dest_o == 2'd0 && !c_we_o && z_we_o));
  p_imm_only_z_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_i == 4'd3 && imm_i) |=> (!n_we_o && !v_we_o));
  p_tmod_z_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (op_i == 4'd4 || op_i == 4'd5)) |=> (z_we_o && !n_we_o && !v_we_o && !c_we_o && dest_o == 2'd2));
  p_upper_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wide_i) |=> res_o[W-1:H] == $past(acc_i[W-1:H]));
  p_unused_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op_i > 4'd9) |=> (dest_o == 2'd0 && $countones({n_we_o, v_we_o, z_we_o, c_we_o}) == 0));
endmodule

bind logic_shift_unit logic_shift_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_i(op_i), .wide_i(wide_i), .imm_i(imm_i),
  .acc_i(acc_i), .res_o(res_o), .dest_o(dest_o), .valid_o(valid_o),
  .n_o(n_o), .v_o(v_o), .z_o(z_o), .c_o(c_o),
  .n_we_o(n_we_o), .v_we_o(v_we_o), .z_we_o(z_we_o), .c_we_o(c_we_o)
);

// File: tb/logic_shift_unit_bench.sv
`timescale 1ns/1ps
module logic_shift_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0] op = '0;
  logic wide = 1'b0, imm = 1'b0, msel = 1'b0, cin = 1'b0;
  logic [15:0] acc = '0, mem = '0;
  logic [15:0] res;
  logic [1:0] dest;
  logic valid, n, v, z, c, nwe, vwe, zwe, cwe;
  int total = 0, bad = 0;
  logic mn = 0, mv = 0, mz = 0, mc = 0;
  logic [15:0] e_res;
  logic [1:0] e_dest;
  logic [3:0] e_we;

  always #2 clk = ~clk;

  logic_shift_unit u_logic_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_i(op), .wide_i(wide), .imm_i(imm),
    .mem_sel_i(msel), .acc_i(acc), .mem_i(mem), .c_i(cin), .res_o(res), .dest_o(dest),
    .valid_o(valid), .n_o(n), .v_o(v), .z_o(z), .c_o(c),
    .n_we_o(nwe), .v_we_o(vwe), .z_we_o(zwe), .c_we_o(cwe));

  task automatic model(input logic [3:0] o, input logic wd, im, ms, input logic [15:0] a, m, input logic ci);
    logic [31:0] w, mask, aa, mm, s, r;
    logic tn, tz, tc;
    w = wd ? 16 : 8;
    mask = (32'd1 << w) - 1;
    aa = {16'd0, a} & mask; mm = {16'd0, m} & mask; s = ms ? mm : aa;
    r = 0; tc = 0; e_dest = 0; e_we = 0;
    case (o)
      0: begin r = aa & mm; e_dest = 1; e_we = 4'b1010; end
      1: begin r = aa | mm; e_dest = 1; e_we = 4'b1010; end
      2: begin r = aa ^ mm; e_dest = 1; e_we = 4'b1010; end
      4: begin r = mm | aa; e_dest = 2; e_we = 4'b0010; end
      5: begin r = mm & ~aa & mask; e_dest = 2; e_we = 4'b0010; end
      6: begin r = (s << 1) & mask; tc = s[w-1]; end
      7: begin r = s >> 1; tc = s[0]; end
      8: begin r = ((s << 1) | {31'd0, ci}) & mask; tc = s[w-1]; end
      9: begin r = (s >> 1) | ({31'd0, ci} << (w - 1)); tc = s[0]; end
      default: ;
    endcase
    if (o >= 6 && o <= 9) begin e_dest = ms ? 2 : 1; e_we = 4'b1011; end
    tn = r[w-1]; tz = (r == 0);
    if (o == 3) begin
      e_we = im ? 4'b0010 : 4'b1110;
      tn = mm[w-1];
      if (!im) mv = mm[w-2];
    end
    if (o == 3 || o == 4 || o == 5) tz = ((aa & mm) == 0);
    e_res = wd ? r[15:0] : {a[15:8], r[7:0]};
    if (e_we[3]) mn = tn;
    if (e_we[1]) mz = tz;
    if (e_we[0]) mc = tc;
  endtask

  task automatic check(input string tag, input logic got_ok, input string what);
    total++;
    if (!got_ok) begin bad++; $display("FAIL %s: %s", tag, what); end
  endtask

  task automatic run(input string tag, input logic [3:0] o, input logic wd, im, ms,
                     input logic [15:0] a, m, input logic ci);
    @(negedge clk);
    op = o; wide = wd; imm = im; msel = ms; acc = a; mem = m; cin = ci; start = 1'b1;
    model(o, wd, im, ms, a, m, ci);
    @(negedge clk);
    start = 1'b0;
    check(tag, valid && dest == e_dest && {nwe, vwe, zwe, cwe} == e_we &&
          (e_dest == 0 || res == e_res) && {n, v, z, c} == {mn, mv, mz, mc},
          $sformatf("op=%0d act res=%h dest=%0d we=%b nvzc=%b exp res=%h dest=%0d we=%b nvzc=%b",
                    o, res, dest, {nwe, vwe, zwe, cwe}, {n, v, z, c},
                    e_res, e_dest, e_we, {mn, mv, mz, mc}));
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    check(tag, !valid && dest == 0 && {nwe, vwe, zwe, cwe} == 0 && {n, v, z, c} == {mn, mv, mz, mc},
          $sformatf("idle act valid=%b dest=%0d we=%b nvzc=%b exp 0/0/0000/%b",
                    valid, dest, {nwe, vwe, zwe, cwe}, {n, v, z, c}, {mn, mv, mz, mc}));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] x, y;
    logic [7:0] b [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", !valid && res == 0 && {n, v, z, c} == 0,
          $sformatf("reset act valid=%b res=%h nvzc=%b exp 0/0000/0000", valid, res, {n, v, z, c}));
    // R1 logic ops, both widths
    run("R1", 0, 1, 0, 0, 16'hF0F0, 16'h8F0F, 0);
    run("R1", 1, 1, 0, 0, 16'h0000, 16'h0000, 0);
    run("R1", 2, 0, 0, 0, 16'hAB5A, 16'h12A5, 0);
    run("R1", 2, 0, 0, 0, 16'hAB5A, 16'h125A, 0);
    idle("R10");
    // R2/R3 bit test
    run("R2", 3, 1, 0, 0, 16'h0001, 16'hC000, 0);
    run("R2", 3, 0, 0, 0, 16'h0040, 16'hFF40, 0);
    run("R3", 3, 0, 1, 0, 16'h0001, 16'h0000, 0);
    run("R3", 3, 1, 1, 0, 16'h0000, 16'hFFFF, 0);
    // R4 test-and-modify: z from original operands
    run("R4", 4, 0, 0, 0, 16'h000F, 16'h00F0, 0);
    run("R4", 4, 1, 0, 0, 16'h0101, 16'h0100, 0);
    run("R4", 5, 1, 0, 0, 16'h00FF, 16'hF00F, 0);
    run("R4", 5, 0, 0, 0, 16'h3300, 16'hFF0C, 0);
    // R5/R6/R7/R8 shifts
    run("R5", 6, 0, 0, 0, 16'h7F81, 16'h0000, 0);
    run("R5", 8, 1, 0, 1, 16'h0000, 16'h4001, 1);
    run("R5", 8, 0, 0, 0, 16'hFF00, 16'h0000, 1);
    run("R6", 7, 0, 0, 1, 16'h0000, 16'h8001, 0);
    run("R6", 9, 0, 0, 0, 16'h8002, 16'h0000, 1);
    run("R6", 9, 1, 0, 0, 16'h0001, 16'h0000, 0);
    run("R7", 7, 1, 0, 0, 16'h8000, 16'h1234, 1);
    run("R8", 6, 0, 0, 0, 16'h8040, 16'h0000, 0);
    idle("R11");
    // R12 unused codes
    run("R12", 10, 1, 0, 0, 16'hFFFF, 16'hFFFF, 1);
    run("R12", 15, 0, 0, 1, 16'h1234, 16'h5678, 0);
    idle("R11");
    // R9 chained 32-bit shifts through c
    x = 32'h8123_4567;
    for (int i = 0; i < 4; i++) begin
      run("R9", (i == 0) ? 4'd6 : 4'd8, 0, 0, 1, 16'h0000, {8'h00, x[8*i +: 8]}, c);
      b[i] = res[7:0];
    end
    y = {b[3], b[2], b[1], b[0]};
    check("R9", y == (x << 1) && c == x[31],
          $sformatf("chain left act=%h c=%b exp=%h c=%b", y, c, x << 1, x[31]));
    x = 32'hC3A5_0F01;
    for (int i = 3; i >= 0; i--) begin
      run("R9", (i == 3) ? 4'd7 : 4'd9, 0, 0, 1, 16'h0000, {8'h00, x[8*i +: 8]}, c);
      b[i] = res[7:0];
    end
    y = {b[3], b[2], b[1], b[0]};
    check("R9", y == (x >> 1) && c == x[0],
          $sformatf("chain right act=%h c=%b exp=%h c=%b", y, c, x >> 1, x[0]));
    for (int k = 0; k < 40; k++)
      run("R10", 4'(k % 12), 1'(k % 3 == 0), 1'(k % 5 == 0), 1'(k % 2),
          16'(k * 16'h3B17 + 16'h0900), 16'(k * 16'h51C3 ^ 16'h8080), 1'(k % 7 == 1));
    idle("R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule